// File: doc/BRIEF.md
# Dual-Width FIFO Port with Half-Word Packing

This block is the local-bus side of a FIFO whose entries are 32 bits wide. In wide mode every write strobe pushes a whole word and every read strobe pops one. In narrow mode the local bus carries 16 bits. Successive strobes then fill or drain the two halves of an entry, and the queue advances only after the half chosen by a two-bit advance select. Writes assemble the entry in a staging register before the push. Reads present the selected half of the head entry.

Strobes are enables sampled on the single port clock. A second, register-style path names the half explicitly with an address bit and leaves the strobe half-select alone. In narrow mode a strobe that reaches a full queue (write) or an empty queue (read) still flips that side's half-select. Callers must therefore gate the write strobe with `full` and the read strobe with `empty`. The bench checks the misaligned behaviour that follows when they do not.

Top module: `halfword_fifo_port`

## Requirements
- R1: With `mode16` low, each accepted write (`wr_en` or `reg_wr`) pushes all 32 bits of `wr_data`. Each accepted read pops one entry, and `rd_data` shows the whole head entry during the read.
- R2: With `mode16` high, the strobe half-select on each side starts at the lower half and flips on every strobe. A write takes `wr_data[15:0]`. A read shows the selected half on `rd_data[15:0]` with `rd_data[31:16]` zero.
- R3: `adv_sel` encoding: 2'b01 advances after the lower half and 2'b10 after the upper half. 2'b00 and 2'b11 never advance in narrow mode. A pushed entry is {upper half, lower half} from the staged halves.
- R4: A narrow write while `full` is high discards its data and stages nothing, but it still flips the write half-select.
- R5: A narrow strobe read while `empty` is high pops nothing, but it still flips the read half-select.
- R6: In wide mode, a write while full or a read while empty changes no state: no entry, no count, no half-select.
- R7: `reg_wr`/`reg_rd` access the half named by `reg_half` (0 lower, 1 upper) and never change the strobe half-selects. When a strobe and a register access on the same side meet in one cycle, the strobe wins and the register access is ignored.
- R8: The queue holds DEPTH (default 8) entries. `full` and `empty` are registered and reflect a push or pop from the cycle after it.
- R9: Reset (active-low, asynchronous) empties the queue (`empty`=1, `full`=0), clears the staging halves and sets both half-selects to lower.
- R10: A push and a pop in the same cycle both take effect and leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode16 | input | 1 | 1 = 16-bit port, 0 = 32-bit port |
| adv_sel | input | 2 | Half after which the queue advances (narrow mode) |
| wr_en | input | 1 | Write strobe (enable) |
| wr_data | input | WIDTH | Write data; narrow mode uses the low half |
| rd_en | input | 1 | Read strobe (enable) |
| rd_data | output | WIDTH | Head entry, or selected half in narrow mode |
| reg_wr | input | 1 | Register-style write |
| reg_rd | input | 1 | Register-style read |
| reg_half | input | 1 | Half address bit for register-style access |
| full | output | 1 | Queue full (registered) |
| empty | output | 1 | Queue empty (registered) |

## Verification
Wide-mode bursts, filling to capacity and draining, together with a simultaneous push and pop, separate the pointer and count logic from the packing logic. Narrow-mode sequences are run with each advance select. The result shows whether the push happens on the configured half and whether the halves are assembled in the right order. Writing past full and reading past empty in narrow mode leave the half-selects misaligned on purpose, and the data read back afterwards shows whether the toggle happened. Mixed register and strobe accesses, including collisions, show that the address bit picks the half without moving the strobe sequence.

// File: rtl/hwf_pkg.sv
package hwf_pkg;

  typedef enum logic [1:0] {
    ADV_NONE  = 2'b00,
    ADV_LOWER = 2'b01,
    ADV_UPPER = 2'b10,
    ADV_OFF   = 2'b11
  } adv_sel_e;

  // True when an access to half 'half' (0 lower, 1 upper) completes an entry.
  function automatic logic adv_hit(input logic [1:0] sel, input logic half);
    return ((sel == ADV_LOWER) && !half) || ((sel == ADV_UPPER) && half);
  endfunction

endpackage

// File: rtl/hwf_ring.sv
module hwf_ring #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    fill
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             full_q, full_d, empty_q, empty_d;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign push_ok = push & ~full_q;
  assign pop_ok  = pop & ~empty_q;

  always_comb begin
    wptr_d = push_ok ? bump(wptr_q) : wptr_q;
    rptr_d = pop_ok  ? bump(rptr_q) : rptr_q;
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    full_d  = (cnt_d == CW'(DEPTH));
    empty_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (push_ok || pop_ok) begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic we;
    assign we = push_ok && (wptr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (we) mem[i] <= push_data;
    end
  end

  assign head  = mem[rptr_q];
  assign full  = full_q;
  assign empty = empty_q;
  assign fill  = cnt_q;

endmodule

// File: rtl/hwf_wr_pack.sv
module hwf_wr_pack
  import hwf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int HW = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode16,
  input  logic [1:0]       adv_sel,
  input  logic             wr_en,
  input  logic             reg_wr,
  input  logic             reg_half,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             full,
  output logic             push,
  output logic [WIDTH-1:0] push_data,
  output logic             wr_half
);

  logic          half_q, half_d;
  logic [HW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic          access, sel, stage_en;

  assign access   = wr_en | reg_wr;
  assign sel      = wr_en ? half_q : reg_half;   // strobe has priority
  assign stage_en = mode16 & access;

  always_comb begin
    half_d    = half_q;
    lo_d      = lo_q;
    hi_d      = hi_q;
    push      = 1'b0;
    push_data = wr_data;
    if (!mode16) begin
      push = access & ~full;
    end else if (access) begin
      if (wr_en) half_d = ~half_q;            // flips even when full
      if (!full) begin
        if (sel) hi_d = wr_data[HW-1:0];
        else     lo_d = wr_data[HW-1:0];
        if (adv_hit(adv_sel, sel)) begin
          push      = 1'b1;
          push_data = sel ? {wr_data[HW-1:0], lo_q} : {hi_q, wr_data[HW-1:0]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (stage_en) begin
      half_q <= half_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign wr_half = half_q;

endmodule

// File: rtl/hwf_rd_unpack.sv
module hwf_rd_unpack
  import hwf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int HW = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode16,
  input  logic [1:0]       adv_sel,
  input  logic             rd_en,
  input  logic             reg_rd,
  input  logic             reg_half,
  input  logic [WIDTH-1:0] head,
  input  logic             empty,
  output logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_half
);

  logic half_q, half_d;
  logic access, sel, half_en;

  assign access  = rd_en | reg_rd;
  assign sel     = rd_en ? half_q : reg_half;
  assign half_en = mode16 & rd_en;

  always_comb begin
    half_d = ~half_q;                          // flips even when empty
    if (!mode16) begin
      pop     = access & ~empty;
      rd_data = head;
    end else begin
      pop     = access & ~empty & adv_hit(adv_sel, sel);
      rd_data = {{HW{1'b0}}, (sel ? head[WIDTH-1:HW] : head[HW-1:0])};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (half_en) half_q <= half_d;
  end

  assign rd_half = half_q;

endmodule

// File: rtl/halfword_fifo_port.sv
module halfword_fifo_port #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode16,
  input  logic [1:0]       adv_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_half,
  output logic             full,
  output logic             empty
);

  logic             push, pop;
  logic [WIDTH-1:0] push_data, head;
  logic             wr_half, rd_half;
  logic [CW-1:0]    fill;

  hwf_wr_pack #(.WIDTH(WIDTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .adv_sel(adv_sel),
    .wr_en(wr_en), .reg_wr(reg_wr), .reg_half(reg_half), .wr_data(wr_data),
    .full(full), .push(push), .push_data(push_data), .wr_half(wr_half)
  );

  hwf_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .head(head), .full(full), .empty(empty), .fill(fill)
  );

  hwf_rd_unpack #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .adv_sel(adv_sel),
    .rd_en(rd_en), .reg_rd(reg_rd), .reg_half(reg_half), .head(head),
    .empty(empty), .pop(pop), .rd_data(rd_data), .rd_half(rd_half)
  );

endmodule

// File: rtl/hwf_checker.sv
module hwf_checker #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode16,
  input logic          wr_en,
  input logic          rd_en,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          full,
  input logic          empty,
  input logic          wr_half,
  input logic          rd_half,
  input logic [CW-1:0] fill
);

  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_wr_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && wr_en) |=> (wr_half != $past(wr_half)));

  p_rd_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && rd_en) |=> (rd_half != $past(rd_half)));

  p_wide_half_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode16 |=> ($stable(wr_half) && $stable(rd_half)));

  p_full_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en && !reg_rd) |=> (fill == $past(fill)));

  p_empty_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en && !reg_wr) |=> empty);

  p_reg_keeps_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> ($stable(wr_half) && $stable(rd_half)));

endmodule

bind halfword_fifo_port hwf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode16(mode16), .wr_en(wr_en), .rd_en(rd_en),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .full(full), .empty(empty),
  .wr_half(wr_half), .rd_half(rd_half), .fill(fill)
);

// File: tb/halfword_fifo_port_bench.sv
module halfword_fifo_port_bench;

  localparam int DEPTH = 8;
  localparam int WIDTH = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic mode16, wr_en, rd_en, reg_wr, reg_rd, reg_half, full, empty;
  logic [1:0] adv_sel;
  logic [31:0] wr_data, rd_data;

  int checks = 0, errors = 0, pre_size = 0;
  bit run = 0, done = 0;
  logic m_wr_half, m_rd_half;
  logic [15:0] m_lo, m_hi;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;   // 125 MHz

  halfword_fifo_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_halfword_fifo_port (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .adv_sel(adv_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_half(reg_half),
    .full(full), .empty(empty)
  );

  function automatic bit hit(input logic [1:0] s, input logic h);
    return (s == 2'b01 && !h) || (s == 2'b10 && h);   // R3 encoding
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // fill level after each edge
  always @(posedge clk) begin
    #1 pre_size = exp_q.size();
  end

  // driver: one cycle of stimulus, expected entries go into the scoreboard
  task automatic step(input logic we, input logic [31:0] wd, input logic rw,
                      input logic rh, input logic re, input logic rr);
    logic h;
    bit fullm;
    @(negedge clk);
    wr_en = we; wr_data = wd; reg_wr = rw; reg_half = rh; rd_en = re; reg_rd = rr;
    if (we || rw) begin
      fullm = (pre_size >= DEPTH);
      h = we ? m_wr_half : rh;
      if (!mode16) begin
        if (!fullm) exp_q.push_back(wd);                  // R1 / R6
      end else begin
        if (we) m_wr_half = ~m_wr_half;                     // R4 flips even if full
        if (!fullm) begin
          if (hit(adv_sel, h)) exp_q.push_back(h ? {wd[15:0], m_lo} : {m_hi, wd[15:0]});
          if (h) m_hi = wd[15:0]; else m_lo = wd[15:0];
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 32'h0, 0, 0, 0, 0);
  endtask

  // monitor: compares reads and flags against the scoreboard
  initial begin
    logic h;
    logic [31:0] e;
    forever begin
      @(negedge clk);
      #2;
      if (run) begin
        chk(full === (pre_size == DEPTH), "R8 full flag", {31'b0, full}, {31'b0, pre_size == DEPTH});
        chk(empty === (pre_size == 0), "R8 empty flag", {31'b0, empty}, {31'b0, pre_size == 0});
        if (rd_en || reg_rd) begin
          h = rd_en ? m_rd_half : reg_half;
          if (!mode16) begin
            if (pre_size > 0 && exp_q.size() > 0) begin
              chk(rd_data === exp_q[0], "R1 wide read", rd_data, exp_q[0]);
              void'(exp_q.pop_front());
            end
          end else begin
            if (pre_size > 0 && exp_q.size() > 0) begin
              e = {16'h0, (h ? exp_q[0][31:16] : exp_q[0][15:0])};
              chk(rd_data === e, rd_en ? "R2 narrow strobe read" : "R7 register read", rd_data, e);
              if (hit(adv_sel, h)) void'(exp_q.pop_front());
            end
            if (rd_en) m_rd_half = ~m_rd_half;              // R5 flips even if empty
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    rst_n = 0; mode16 = 0; adv_sel = 2'b10;
    wr_en = 0; rd_en = 0; reg_wr = 0; reg_rd = 0; reg_half = 0; wr_data = 0;
    m_wr_half = 0; m_rd_half = 0; m_lo = 0; m_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(empty === 1'b1, "R9 empty after reset", {31'b0, empty}, 32'h1);
    chk(full === 1'b0, "R9 full after reset", {31'b0, full}, 32'h0);
    run = 1;

    // R1 wide burst
    step(1, 32'hA1A1_0001, 0, 0, 0, 0);
    step(1, 32'hA2A2_0002, 0, 0, 0, 0);
    step(1, 32'hA3A3_0003, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0);
    idle(1);

    // R8 fill to capacity, R6 write while full and read while empty
    for (int i = 0; i < DEPTH; i++) step(1, 32'h1000_0000 + i, 0, 0, 0, 0);
    step(1, 32'hDEAD_BEEF, 0, 0, 0, 0);
    idle(1);
    chk(full === 1'b1, "R6 still full after ignored write", {31'b0, full}, 32'h1);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    idle(1);
    chk(empty === 1'b1, "R6 empty after ignored read", {31'b0, empty}, 32'h1);
    step(1, 32'h5555_AAAA, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);

    // R10 simultaneous push and pop
    step(1, 32'hB0B0_0001, 0, 0, 0, 0);
    step(1, 32'hB0B0_0002, 0, 0, 0, 0);
    step(1, 32'hB0B0_0003, 0, 0, 1, 0);
    idle(1);
    chk(empty === 1'b0 && full === 1'b0, "R10 level kept", {30'b0, full, empty}, 32'h0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    idle(1);
    chk(empty === 1'b1, "R10 drained", {31'b0, empty}, 32'h1);

    // R2/R3 narrow, advance after upper
    mode16 = 1; adv_sel = 2'b10;
    for (int i = 0; i < 6; i++) step(1, 32'hFFFF_C000 + i, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 0);
    idle(1);

    // R3 advance after lower
    adv_sel = 2'b01;
    step(1, 32'h0000_D001, 0, 0, 0, 0);
    step(1, 32'h0000_D002, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    idle(1);

    // R3 no advance for 00 and 11
    adv_sel = 2'b00;
    step(1, 32'h0000_E001, 0, 0, 0, 0);
    step(1, 32'h0000_E002, 0, 0, 0, 0);
    idle(1);
    chk(empty === 1'b1, "R3 select 00 never pushes", {31'b0, empty}, 32'h1);
    adv_sel = 2'b11;
    step(1, 32'h0000_E003, 0, 0, 0, 0);
    step(1, 32'h0000_E004, 0, 0, 0, 0);
    idle(1);
    chk(empty === 1'b1, "R3 select 11 never pushes", {31'b0, empty}, 32'h1);

    // R4 narrow write while full, then misaligned packing
    adv_sel = 2'b10;
    for (int i = 0; i < 2 * DEPTH; i++) step(1, 32'h0000_F000 + i, 0, 0, 0, 0);
    step(1, 32'h0000_BAD0, 0, 0, 0, 0);
    idle(1);
    chk(full === 1'b1, "R4 full after narrow fill", {31'b0, full}, 32'h1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0);
    step(1, 32'h0000_7001, 0, 0, 0, 0);
    step(1, 32'h0000_7002, 0, 0, 0, 0);
    for (int i = 0; i < 2 * DEPTH; i++) step(0, 0, 0, 0, 1, 0);
    idle(1);
    chk(empty === 1'b1, "R4 drained", {31'b0, empty}, 32'h1);

    // R5 narrow read while empty, then misaligned unpacking
    step(0, 0, 0, 0, 1, 0);
    step(1, 32'h0000_9001, 0, 0, 0, 0);
    step(1, 32'h0000_9002, 0, 0, 0, 0);
    step(1, 32'h0000_9003, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0);
    idle(1);
    chk(empty === 1'b1, "R5 drained", {31'b0, empty}, 32'h1);

    // R7 register-style access and strobe priority
    step(0, 32'h0000_1111, 1, 0, 0, 0);
    step(0, 32'h0000_2222, 1, 1, 0, 0);
    step(1, 32'h0000_3333, 1, 1, 0, 0);
    step(1, 32'h0000_4444, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 1, 0);
    idle(1);
    chk(empty === 1'b1, "R7 register path drained", {31'b0, empty}, 32'h1);
    chk(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 32'h0);

    idle(2);
    finish_run();
  end

endmodule